// File: doc/BRIEF.md
# Paged Indirect Effective-Address Unit

This block turns the address part of a memory-reference instruction into the final 12-bit word address for a small word-addressed processor with a 4,096-word memory. The caller pulses `start` with the instruction word and the address of that instruction. The unit forms a direct address in one of two ways. When the page flag is clear it uses page zero, with the upper five bits set to zero. When the page flag is set it uses the current page, taking the upper five bits from the instruction's own address. If the indirect flag is set, the unit reads one pointer word from memory, and that word becomes the result.

Eight pointer locations near the bottom of memory, octal 0010 through 0017, act as auto-index registers. When one of them is used indirectly, the unit adds one to the pointer, wrapping at 4096, and writes the new value back. The incremented value is then used as the effective address. The memory is reached through a plain synchronous port with one cycle of read latency. The result appears on `ea` together with a one-cycle `done` pulse.

Bit numbering follows the processor convention: bit 0 is the most significant bit. So instruction bit 0 maps to `instr[11]` and bit 11 maps to `instr[0]`.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `mem_re` and `mem_we` are all 0.
- R2: With the page flag `instr[7]` at 0, the direct address is `{5'b0, instr[6:0]}`, which lies in page zero.
- R3: With the page flag `instr[7]` at 1, the direct address is `{pc[11:7], instr[6:0]}`, which lies in the current page.
- R4: With the indirect flag `instr[8]` at 0, `ea` equals the direct address and `done` rises in the cycle after `start` is accepted. Neither `mem_re` nor `mem_we` is asserted.
- R5: With `instr[8]` at 1 and the direct address outside octal 0010–0017, the unit makes one read at the direct address and `ea` equals the word read. `done` comes three cycles after acceptance, and no write is made.
- R6: With `instr[8]` at 1 and direct address bits [11:3] equal to 9'b000000001, the unit writes the pointer plus one back to the direct address. That incremented value is `ea`, and `done` comes four cycles after acceptance. This holds for either page flag.
- R7: The auto-index increment wraps modulo 4096, so octal 7777 becomes 0000.
- R8: `done` is high for exactly one cycle, and `busy` is high from the cycle after acceptance through the `done` cycle.
- R9: `start` is accepted only while `busy` is 0. While `busy` is 1, `start`, `instr` and `pc` have no effect, because the inputs are captured at acceptance.
- R10: The opcode field `instr[11:9]` has no effect on `ea`, on the latency or on memory traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a computation; taken only when idle |
| instr | input | 12 | Instruction word |
| pc | input | 12 | Address of the current instruction |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse; `ea` valid |
| ea | output | 12 | Effective address |
| mem_addr | output | 12 | Memory word address |
| mem_re | output | 1 | Memory read strobe; data on `mem_rdata` one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data |

## Verification
The unit is tried with four kinds of direct address: page zero, current page, plain indirect, and auto-index indirect. Each kind tells apart the address formula, the latency and the memory traffic that the unit produces. Directed cases sit on the window edges at octal 0007, 0010, 0017 and 0020, which separate a correct nine-bit compare from an off-by-one one. A pointer holding 7777 exposes a missing wrap. A current-page reference from a page-zero instruction shows that the window test uses the formed address and not the page flag. Random instruction and address pairs against a behavioural memory check the write-back in memory. Further runs hold `start` high with other inputs during a computation, or vary only the opcode, to show that neither changes the result.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int WORD_W = 12;
  localparam int OFS_W  = 7;
  localparam int OPC_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_WRITE,
    ST_DONE
  } ea_state_e;
endpackage

// File: rtl/ea_decode.sv
module ea_decode #(
  parameter int WORD_W   = ea_pkg::WORD_W,
  parameter int OFS_W    = ea_pkg::OFS_W,
  parameter int OPC_W    = ea_pkg::OPC_W,
  parameter int AUTO_LSB = 3,
  parameter int AUTO_TAG = 1
) (
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] dir_addr,
  output logic              indirect,
  output logic              auto_idx
);
  localparam int PAGE_W  = WORD_W - OFS_W;
  localparam int IND_BIT = WORD_W - OPC_W - 1;
  localparam int PG_BIT  = IND_BIT - 1;
  localparam int TAG_W   = WORD_W - AUTO_LSB;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(AUTO_TAG);

  logic [PAGE_W-1:0] page_base;
  logic              unused_bits;

  // opcode and in-page pc bits take no part in address formation
  assign unused_bits = ^{instr[WORD_W-1:IND_BIT+1], pc[OFS_W-1:0]};

  assign indirect  = instr[IND_BIT];
  assign page_base = instr[PG_BIT] ? pc[WORD_W-1 -: PAGE_W] : '0;
  assign dir_addr  = {page_base, instr[OFS_W-1:0]};
  assign auto_idx  = indirect && (dir_addr[WORD_W-1:AUTO_LSB] == TAG);
endmodule

// File: rtl/ea_ptr_inc.sv
module ea_ptr_inc #(
  parameter int WORD_W = ea_pkg::WORD_W
) (
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out
);
  // natural modulo 2**WORD_W wrap
  assign word_out = word_in + WORD_W'(1);
endmodule

// File: rtl/ea_fsm.sv
module ea_fsm
  import ea_pkg::*;
#(
  parameter int WORD_W = ea_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] dir_addr,
  input  logic              indirect,
  input  logic              auto_idx,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] inc_word,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] ea,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata
);
  ea_state_e         state;
  logic              auto_q;
  logic [WORD_W-1:0] ea_q, addr_q, wdata_q;
  logic              re_q, we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      auto_q  <= 1'b0;
      ea_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      re_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      re_q <= 1'b0;
      we_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            auto_q <= auto_idx;
            addr_q <= dir_addr;
            if (indirect) begin
              re_q  <= 1'b1;
              state <= ST_READ;
            end else begin
              ea_q  <= dir_addr;
              state <= ST_DONE;
            end
          end
        end
        ST_READ:  state <= ST_LOAD;
        ST_LOAD: begin
          if (auto_q) begin
            ea_q    <= inc_word;
            wdata_q <= inc_word;
            we_q    <= 1'b1;
            state   <= ST_WRITE;
          end else begin
            ea_q  <= mem_rdata;
            state <= ST_DONE;
          end
        end
        ST_WRITE: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign ea        = ea_q;
  assign mem_addr  = addr_q;
  assign mem_re    = re_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int WORD_W   = ea_pkg::WORD_W,
  parameter int OFS_W    = ea_pkg::OFS_W,
  parameter int OPC_W    = ea_pkg::OPC_W,
  parameter int AUTO_LSB = 3,
  parameter int AUTO_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] ea,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic [WORD_W-1:0] dir_addr, inc_word;
  logic              indirect, auto_idx;

  ea_decode #(
    .WORD_W(WORD_W), .OFS_W(OFS_W), .OPC_W(OPC_W),
    .AUTO_LSB(AUTO_LSB), .AUTO_TAG(AUTO_TAG)
  ) u_decode (
    .instr(instr), .pc(pc), .dir_addr(dir_addr),
    .indirect(indirect), .auto_idx(auto_idx)
  );

  ea_ptr_inc #(.WORD_W(WORD_W)) u_inc (
    .word_in(mem_rdata), .word_out(inc_word)
  );

  ea_fsm #(.WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .dir_addr(dir_addr), .indirect(indirect), .auto_idx(auto_idx),
    .mem_rdata(mem_rdata), .inc_word(inc_word),
    .busy(busy), .done(done), .ea(ea),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk #(
  parameter int WORD_W = ea_pkg::WORD_W,
  parameter int OFS_W  = ea_pkg::OFS_W,
  parameter int OPC_W  = ea_pkg::OPC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [WORD_W-1:0] instr,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] ea,
  input logic              mem_re,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_wdata
);
  localparam int IND_BIT = WORD_W - OPC_W - 1;
  localparam int PG_BIT  = IND_BIT - 1;

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(posedge clk)
    if (rst_q) reset_quiet_chk: assert (!busy && !done && !mem_re && !mem_we);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  direct_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !instr[IND_BIT]) |=> (done && !mem_re && !mem_we));

  // R2
  page_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !instr[IND_BIT] && !instr[PG_BIT])
      |=> (ea == WORD_W'($past(instr[OFS_W-1:0]))));

  // R5
  read_once_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && busy && !done));

  // R6
  write_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> done);

  // R6
  write_matches_ea_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == ea && !mem_re));

  // R9
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

bind eff_addr_unit eff_addr_unit_chk #(
  .WORD_W(WORD_W), .OFS_W(OFS_W), .OPC_W(OPC_W)
) i_chk (
  .clk(clk), .rst(rst), .start(start), .instr(instr),
  .busy(busy), .done(done), .ea(ea),
  .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/test_eff_addr_unit.sv
`timescale 1ns/1ps
module test_eff_addr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [11:0] instr_i = '0, pc_i = '0;
  logic        busy, done, mem_re, mem_we;
  logic [11:0] ea, mem_addr, mem_wdata;
  logic [11:0] mem_rdata = '0;
  logic [11:0] mem [4096];
  int          n_chk = 0, n_err = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  eff_addr_unit i_eff_addr_unit (
    .clk(clk), .rst(rst), .start(start), .instr(instr_i), .pc(pc_i),
    .busy(busy), .done(done), .ea(ea), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0o expected %0o", req, act, exp);
    end
  endtask

  function automatic logic [11:0] f_dir(input logic [11:0] ins, input logic [11:0] p);
    return ins[7] ? {p[11:7], ins[6:0]} : {5'b0, ins[6:0]};
  endfunction

  function automatic bit f_auto(input logic [11:0] ins, input logic [11:0] p);
    logic [11:0] d;
    d = f_dir(ins, p);
    return ins[8] && (d[11:3] == 9'd1);
  endfunction

  task automatic do_op(input logic [11:0] ins, input logic [11:0] p, input bit hold);
    logic [11:0] d, old, exp_ea;
    bit          ind, aut, saw_re, saw_we;
    int          cnt, exp_lat;
    string       tg;
    d      = f_dir(ins, p);
    ind    = ins[8];
    aut    = f_auto(ins, p);
    old    = mem[d];
    exp_ea = aut ? old + 12'd1 : (ind ? old : d);
    exp_lat = aut ? 4 : (ind ? 3 : 1);
    tg = aut ? "R6" : (ind ? "R5" : (ins[7] ? "R3" : "R2"));
    if (hold) tg = "R9";
    @(negedge clk);
    start = 1'b1; instr_i = ins; pc_i = p;
    @(negedge clk);
    if (!hold) start = 1'b0;
    instr_i = 12'($urandom); pc_i = 12'($urandom);
    cnt = 1; saw_re = 0; saw_we = 0;
    while (!done && cnt < 12) begin
      saw_re |= mem_re; saw_we |= mem_we;
      @(negedge clk); cnt++;
    end
    start = 1'b0;
    chk(ea == exp_ea, tg, ea, exp_ea);
    chk(cnt == exp_lat, ind ? tg : "R4", cnt, exp_lat);
    chk(saw_re == ind && saw_we == aut, ind ? tg : "R4", {saw_re, saw_we}, {ind, aut});
    chk(busy == 1'b1, "R8", busy, 1);
    @(negedge clk);
    chk(!done && !busy, "R8", {done, busy}, 0);
    chk(mem[d] == (aut ? exp_ea : old), aut ? "R6" : "R5", mem[d], aut ? exp_ea : old);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] ins, p;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) mem[i] = 12'($urandom);
    mem[12'o0012] = 12'o7777;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R1", {busy, done, mem_re, mem_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R1", {busy, done, mem_re, mem_we}, 0);

    do_op(12'o1055, 12'o4321, 0);   // R2 page zero direct
    do_op(12'o1255, 12'o4321, 0);   // R3 current page direct
    do_op(12'o1455, 12'o4321, 0);   // R5 page zero indirect
    do_op(12'o1655, 12'o4321, 0);   // R5 current page indirect
    do_op(12'o0412, 12'o0000, 0);   // R7 pointer 7777 wraps to 0000
    chk(mem[12'o0012] == 12'o0000, "R7", mem[12'o0012], 0);
    do_op(12'o0410, 12'o2000, 0);   // R6 low window edge
    do_op(12'o0417, 12'o2000, 0);   // R6 high window edge
    do_op(12'o0407, 12'o2000, 0);   // R5 just below window
    do_op(12'o0420, 12'o2000, 0);   // R5 just above window
    do_op(12'o0613, 12'o0042, 0);   // R6 current page in page zero
    do_op(12'o0613, 12'o0242, 0);   // R5 current page elsewhere
    do_op(12'o1414, 12'o0000, 1);   // R9 start held during auto-index
    do_op(12'o1033, 12'o0000, 1);   // R9 start held during direct
    // R10 opcode variants with identical address fields
    for (int op = 0; op < 8; op++) begin
      do_op({3'(op), 9'o455}, 12'o6100, 0);
      do_op({3'(op), 9'o233}, 12'o6100, 0);
    end
    for (int i = 0; i < 150; i++) begin
      ins = 12'($urandom);
      p   = 12'($urandom);
      if ((i % 4) == 0) begin
        ins[8] = 1'b1; ins[7] = 1'b0; ins[6:0] = 7'(8 + ($urandom % 8));
      end
      do_op(ins, p, 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule